// File: doc/BRIEF.md
# Receive Byte Queue with Character-Gap Timeout

This block buffers bytes delivered by a serial receiver in a small first-in first-out store and tells the CPU when to collect them. A level-type threshold interrupt is raised once the number of stored bytes reaches a selectable level: either a single byte, or half of the store. A threshold on its own can leave a few bytes stranded. With half-full selected, three waiting bytes never raise it, however long the line stays quiet.

To close that gap, the block holds a retriggerable gap timer. It counts character-time ticks while the store holds data. Every arriving byte and every CPU read restarts it. When the programmed number of character times passes with no new byte, a separate timeout interrupt is raised. That interrupt stays up until the CPU reads a byte.

A byte that arrives when the store is full is discarded and sets a sticky overrun flag, which a status read clears. The head byte is always presented on the read data port. A read strobe removes it.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the level is 0 and thr_irq, tmo_irq and overrun are all 0.
- R2: Bytes leave in arrival order. rd_data always shows the oldest stored byte, and a read strobe removes it. A read strobe while the store is empty has no effect and the level stays 0.
- R3: The store holds 8 bytes and level reports how many are held, updated one cycle after the strobe. A byte arrival and a read strobe in the same cycle leave the level unchanged, even at 8: the read frees the slot and the new byte is kept.
- R4: With cfg_half = 0, thr_irq is 1 whenever level >= 1. With cfg_half = 1, thr_irq is 1 whenever level >= 4. It falls as soon as the level drops below the selected threshold.
- R5: A byte arriving at level 8 with no read strobe in that cycle is discarded and the level stays 8. The overrun flag is set the next cycle and stays set until a cycle with stat_rd. If a discard and stat_rd fall in the same cycle, the flag is set.
- R6: While the level is non-zero and no byte arrives and no read occurs, tmo_irq becomes 1 in the cycle after the cfg_gap-th char_tick.
- R7: Any arriving byte, whether kept or discarded, and any read of a non-empty store restart the gap count at zero. A char_tick in the same cycle as an arriving byte is not counted.
- R8: tmo_irq stays 1 until a read of a non-empty store clears it, and an arriving byte does not clear it. No ticks are counted while the store is empty. With cfg_gap = 0 the timeout never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receiver delivers a byte this cycle |
| in_data | input | 8 | Byte from the receiver |
| char_tick | input | 1 | One-cycle pulse per character time |
| rd_en | input | 1 | CPU read strobe, removes the head byte |
| stat_rd | input | 1 | CPU status read, clears overrun |
| cfg_half | input | 1 | Threshold select: 0 means 1 byte, 1 means half full |
| cfg_gap | input | 8 | Timeout length in character times, 0 disables |
| rd_data | output | 8 | Oldest stored byte |
| level | output | 4 | Number of stored bytes |
| thr_irq | output | 1 | Threshold interrupt, level-type |
| tmo_irq | output | 1 | Character-gap timeout interrupt |
| overrun | output | 1 | Sticky flag: a byte was discarded |

## Verification
The collisions that matter are an arriving byte landing in the same cycle as a character tick, and an arriving byte landing in the same cycle as a CPU read. The bench drives each pair on purpose. For the first pair it checks that the timeout fires only after a full cfg_gap further ticks, which shows the coincident tick was not counted. For the second pair, at level 1 and again at level 8, it checks that the level holds and that the scoreboard sees the popped byte in order. It also checks that the queued byte later comes out intact. A discard landing on a status read is judged by the overrun flag staying set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic {
        THR_ONE  = 1'b0,
        THR_HALF = 1'b1
    } thr_sel_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              pop_ok,
    output logic              drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok;

    always_comb begin
        pop_ok  = rd_req && (st_q.cnt != '0);
        push_ok = wr_req && ((st_q.cnt != FULL_LVL) || pop_ok);
        drop    = wr_req && !push_ok;
        st_d    = st_q;
        if (push_ok) st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + 1'b1;
        if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wr_data;
    end

    assign rd_data = mem_q[st_q.rp];
    assign level   = st_q.cnt;

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    assert_drop_keeps_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (level == FULL_LVL));
endmodule

// File: rtl/rxq_gap_timer.sv
module rxq_gap_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             armed,
    input  logic             tick,
    input  logic             clear,
    input  logic [TMO_W-1:0] limit,
    output logic             irq
);
    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             irq;
    } gap_t;

    gap_t g_d, g_q;
    logic [TMO_W:0] cnt_inc;

    always_comb begin
        g_d     = g_q;
        cnt_inc = {1'b0, g_q.cnt} + 1'b1;
        if (restart || !armed) begin
            g_d.cnt = '0;
        end else if (tick && (g_q.cnt != '1)) begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
        if (clear) begin
            g_d.irq = 1'b0;
        end else if (!restart && armed && tick && (limit != '0)
                     && (cnt_inc >= {1'b0, limit})) begin
            g_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign irq = g_q.irq;

    assert_restart_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !$rose(irq));
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !irq);
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int TMO_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            in_data,
    input  logic                         char_tick,
    input  logic                         rd_en,
    input  logic                         stat_rd,
    input  logic                         cfg_half,
    input  logic [TMO_W-1:0]             cfg_gap,
    output logic [DATA_W-1:0]            rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         thr_irq,
    output logic                         tmo_irq,
    output logic                         overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] ONE_LVL  = CNT_W'(1);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    typedef struct packed {
        logic ovr;
    } flag_t;

    flag_t f_d, f_q;
    logic pop_ok, drop;
    logic [CNT_W-1:0] thr_lvl;
    thr_sel_e thr_sel;

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (in_valid),
        .wr_data (in_data),
        .rd_req  (rd_en),
        .rd_data (rd_data),
        .level   (level),
        .pop_ok  (pop_ok),
        .drop    (drop)
    );

    rxq_gap_timer #(.TMO_W(TMO_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (in_valid || pop_ok),
        .armed   (level != '0),
        .tick    (char_tick),
        .clear   (pop_ok),
        .limit   (cfg_gap),
        .irq     (tmo_irq)
    );

    always_comb begin
        thr_sel = thr_sel_e'(cfg_half);
        thr_lvl = (thr_sel == THR_HALF) ? HALF_LVL : ONE_LVL;
        thr_irq = (level >= thr_lvl);
        f_d     = f_q;
        if (drop)         f_d.ovr = 1'b1;
        else if (stat_rd) f_d.ovr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign overrun = f_q.ovr;

    assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (level == FULL_LVL) && !rd_en) |=> overrun);
    assert_tmo_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> (level != '0));
endmodule

// File: tb/tb_rx_byte_queue.sv
module tb_rx_byte_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       char_tick = 1'b0;
    logic       rd_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       cfg_half = 1'b0;
    logic [7:0] cfg_gap = 8'd5;
    logic [7:0] rd_data;
    logic [3:0] level;
    logic       thr_irq, tmo_irq, overrun;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    rx_byte_queue dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .char_tick(char_tick), .rd_en(rd_en), .stat_rd(stat_rd),
        .cfg_half(cfg_half), .cfg_gap(cfg_gap), .rd_data(rd_data),
        .level(level), .thr_irq(thr_irq), .tmo_irq(tmo_irq), .overrun(overrun)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // inputs change 2 ns after a rising edge; registered results are visible then
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // monitor: compares the head byte on every read cycle (R2 ordering)
    always @(negedge clk) begin
        if (rst_n && rd_en && exp_q.size() > 0) begin
            checks++;
            if (rd_data !== exp_q[0]) begin
                errors++;
                $display("FAIL R2 order: actual=%0h expected=%0h", rd_data, exp_q[0]);
            end
            void'(exp_q.pop_front());
        end
    end

    task automatic push(input logic [7:0] d, input bit with_tick = 1'b0);
        in_valid = 1'b1; in_data = d; char_tick = with_tick;
        if (exp_q.size() < 8) exp_q.push_back(d);
        step();
        in_valid = 1'b0; char_tick = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic push_pop(input logic [7:0] d);
        in_valid = 1'b1; in_data = d; rd_en = 1'b1;
        exp_q.push_back(d);
        step();
        in_valid = 1'b0; rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1; step();
            char_tick = 1'b0; step();
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 level", level, 0);
        check("R1 thr_irq", thr_irq, 0);
        check("R1 tmo_irq", tmo_irq, 0);
        check("R1 overrun", overrun, 0);

        // three bytes under half-full threshold, then timeout
        cfg_half = 1'b1; cfg_gap = 8'd5;
        push(8'h11); push(8'h22); push(8'h33);
        check("R3 level 3", level, 3);
        check("R4 half below", thr_irq, 0);
        ticks(4);
        check("R6 before gap", tmo_irq, 0);
        ticks(1);
        check("R6 at gap", tmo_irq, 1);
        pop();
        check("R8 read clears", tmo_irq, 0);
        check("R3 level 2", level, 2);

        // byte coinciding with a tick: the tick must not count
        ticks(4);
        push(8'h44, 1'b1);
        ticks(4);
        check("R7 coincident tick", tmo_irq, 0);
        ticks(1);
        check("R7 full gap after byte", tmo_irq, 1);
        push(8'h55);
        check("R4 half reached", thr_irq, 1);
        check("R8 byte keeps irq", tmo_irq, 1);
        pop();
        check("R4 below half", thr_irq, 0);

        // one-byte threshold, drain, empty read, no counting when empty
        cfg_half = 1'b0;
        step();
        check("R4 one-byte thr", thr_irq, 1);
        pop(); pop(); pop();
        check("R2 drained", level, 0);
        check("R4 empty", thr_irq, 0);
        pop();
        check("R2 empty read", level, 0);
        ticks(6);
        check("R8 idle empty", tmo_irq, 0);

        // fill, overrun, full write+read, status clear
        for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
        check("R3 full", level, 8);
        push(8'hEE);
        check("R5 level held", level, 8);
        check("R5 overrun set", overrun, 1);
        step();
        check("R5 sticky", overrun, 1);
        push_pop(8'hB8);
        check("R3 full push+pop", level, 8);
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        check("R5 status clears", overrun, 0);
        stat_rd = 1'b1; push(8'hEF); stat_rd = 1'b0;
        check("R5 set wins", overrun, 1);
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        check("R5 cleared again", overrun, 0);
        for (int i = 0; i < 8; i++) pop();
        check("R2 drained full", level, 0);
        check("R2 scoreboard empty", exp_q.size(), 0);

        // disabled timeout
        cfg_gap = 8'd0;
        push(8'h5A);
        ticks(20);
        check("R8 gap zero", tmo_irq, 0);

        // write+read same cycle at level 1
        push_pop(8'h6B);
        check("R3 push+pop level", level, 1);
        pop();
        check("R3 final level", level, 0);
        check("R2 final scoreboard", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule